// File: doc/BRIEF.md
# DRAM Rank Power-Down Controller

This block decides, rank by rank, when a DDR3-style memory interface may drop its clock-enable and rest. It looks at which ranks are fitted, whether any bank in each rank still holds an open page, which ranks have requests waiting, and how deeply the processor is sleeping. A populated rank that stays idle long enough drops CKE during normal operation. It enters active power-down if any page is still open, and precharge power-down if all pages are closed. A request to a resting rank raises CKE again. The rank then holds off commands for a fixed wake latency before it reports ready.

A single self-refresh controller puts every populated rank into self-refresh together. This happens when software asks for it, or when the processor sits in its deepest sleep and no request has arrived for a programmable quiet interval. The ranks leave self-refresh on a new request, or when the condition that caused entry goes away. The block also drives the output enables of the pins. The address/command bus is driven only while a chip select is requested and some rank is awake. A chip select is driven only for an awake rank. CKE and chip select of an empty rank, and the clock of an empty slot, are never driven.

Top module: `dram_rank_pd_ctrl`

## Requirements
- R1: An active, populated, ready rank with no pending request for `idle_limit` consecutive cycles drops CKE at the edge that ends the last of those cycles. A limit of 0 behaves as 1. A pending request, or a cycle still inside the wake latency, restarts the count.
- R2: Each rank reports its state on two bits of `rank_state`, at bit position 2r: 00 active, 01 active power-down, 10 precharge power-down, 11 self-refresh. On idle entry, the rank's `bank_open` value in the final idle cycle selects the state: 1 gives 01 and 0 gives 10.
- R3: A pending request to a rank in state 01 or 10 returns it to 00 with CKE high at the next edge. `rank_ready` then stays low for `PD_EXIT_CYC` (4) cycles and rises after that.
- R4: While `cpu_deep_sleep` is high and no populated rank has a pending request for `quiet_limit` consecutive cycles (a limit of 0 behaves as 1), every populated rank enters 11 and `sr_active` rises at the edge that ends the last such cycle.
- R5: `sw_sr_req` high in a cycle with no pending request to a populated rank puts every populated rank into 11 at the next edge, whatever the sleep level.
- R6: Self-refresh ends at the edge after any of these: a pending request to a populated rank, `sw_sr_req` going low when it was high at entry, or `cpu_deep_sleep` going low otherwise. All populated ranks then show 00 with CKE high, and `rank_ready` stays low for `SR_EXIT_CYC` (32) cycles. The quiet count restarts.
- R7: `addr_cmd_oe` is high in a cycle only when `cs_req` is set for some populated rank and at least one populated rank is in state 00. It follows `cs_req` in the same cycle.
- R8: `cs_oe[r]` is high exactly when rank r is populated and in state 00.
- R9: For an unpopulated rank, `cke`, `cke_oe`, `cs_oe` and `rank_ready` stay low and its state reads 00. Its requests affect nothing. `clk_oe[s]` is high exactly when some rank of slot s (ranks s*RANKS_PER_SLOT upward) is populated.
- R10: After reset every populated rank is in 00, ready, with CKE high, and `sr_active` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rank_populated | input | NUM_RANKS | Rank fitted mask |
| bank_open | input | NUM_RANKS | Some page open in the rank |
| req_pending | input | NUM_RANKS | Request waiting for the rank |
| cs_req | input | NUM_RANKS | Scheduler chip-select demand this cycle |
| cpu_deep_sleep | input | 1 | Processor in deepest sleep level |
| sw_sr_req | input | 1 | Software self-refresh request (level) |
| idle_limit | input | IDLE_W | Idle cycles before power-down (16 suggested) |
| quiet_limit | input | QUIET_W | Quiet cycles before sleep self-refresh |
| cke | output | NUM_RANKS | Clock-enable per rank |
| rank_state | output | 2*NUM_RANKS | Packed per-rank state codes |
| rank_ready | output | NUM_RANKS | Rank may accept commands |
| sr_active | output | 1 | Ranks are in self-refresh |
| addr_cmd_oe | output | 1 | Address/command pin enable |
| cs_oe | output | NUM_RANKS | Chip-select pin enables |
| cke_oe | output | NUM_RANKS | CKE pin enables |
| clk_oe | output | NUM_SLOTS | Clock pin enables per slot |

## Verification
The assertions rely on the population mask staying constant between resets. They also rely on sleep, software and request inputs changing only between clock edges, so every state transition can be traced to the inputs sampled one edge earlier. The bench changes `rank_populated` only while reset is held, and drives all other inputs just after the falling edge. Requests to unpopulated ranks are driven on purpose, because the design must ignore them rather than the stimulus avoiding them.

// File: rtl/rank_pd_pkg.sv
package rank_pd_pkg;
  typedef enum logic [1:0] {
    PST_ACT = 2'b00,
    PST_APD = 2'b01,
    PST_PPD = 2'b10,
    PST_SR  = 2'b11
  } rank_pst_e;
endpackage

// File: rtl/rank_pd_fsm.sv
module rank_pd_fsm
  import rank_pd_pkg::*;
#(
  parameter int IDLE_W      = 8,
  parameter int EXIT_W      = 6,
  parameter int PD_EXIT_CYC = 4,
  parameter int SR_EXIT_CYC = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              populated,
  input  logic              bank_open,
  input  logic              req,
  input  logic [IDLE_W-1:0] idle_limit,
  input  logic              sr_enter,
  input  logic              sr_exit,
  output rank_pst_e         state_o,
  output logic              ready_o
);
  rank_pst_e          st;
  logic [IDLE_W-1:0]  idle_cnt;
  logic [EXIT_W-1:0]  exit_cnt;
  logic               idle_hit;

  assign idle_hit = ({1'b0, idle_cnt} + 1'b1) >= {1'b0, idle_limit};

  always_ff @(posedge clk) begin
    if (rst || !populated) begin
      st       <= PST_ACT;
      idle_cnt <= '0;
      exit_cnt <= '0;
    end else if (sr_enter) begin
      st       <= PST_SR;
      idle_cnt <= '0;
      exit_cnt <= '0;
    end else if (sr_exit && st == PST_SR) begin
      st       <= PST_ACT;
      idle_cnt <= '0;
      exit_cnt <= EXIT_W'(SR_EXIT_CYC);
    end else begin
      case (st)
        PST_ACT: begin
          if (exit_cnt != '0) begin
            exit_cnt <= exit_cnt - 1'b1;
            idle_cnt <= '0;
          end else if (req) begin
            idle_cnt <= '0;
          end else if (idle_hit) begin
            st       <= bank_open ? PST_APD : PST_PPD;
            idle_cnt <= '0;
          end else begin
            idle_cnt <= idle_cnt + 1'b1;
          end
        end
        PST_APD, PST_PPD: begin
          if (req) begin
            st       <= PST_ACT;
            exit_cnt <= EXIT_W'(PD_EXIT_CYC);
          end
        end
        default: ;
      endcase
    end
  end

  assign state_o = st;
  assign ready_o = populated && st == PST_ACT && exit_cnt == '0;

  AST_PPD_PAGES_CLOSED: assert property (@(posedge clk) disable iff (rst)
    (st == PST_PPD && $past(st) == PST_ACT) |-> !$past(bank_open)); // R2
  AST_APD_PAGE_OPEN: assert property (@(posedge clk) disable iff (rst)
    (st == PST_APD && $past(st) == PST_ACT) |-> $past(bank_open)); // R2
  AST_PD_WAKE: assert property (@(posedge clk) disable iff (rst)
    (populated && req && (st == PST_APD || st == PST_PPD)) |=> (st == PST_ACT && !ready_o)); // R3
endmodule

// File: rtl/sr_ctrl.sv
module sr_ctrl #(
  parameter int QUIET_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               any_req,
  input  logic               cpu_deep_sleep,
  input  logic               sw_sr_req,
  input  logic [QUIET_W-1:0] quiet_limit,
  output logic               sr_active_o,
  output logic               sr_enter_o,
  output logic               sr_exit_o
);
  logic               sr_q;
  logic               by_sw_q;
  logic [QUIET_W-1:0] quiet_cnt;
  logic               quiet_ok;

  always_comb begin
    quiet_ok   = cpu_deep_sleep && !any_req &&
                 (({1'b0, quiet_cnt} + 1'b1) >= {1'b0, quiet_limit});
    sr_enter_o = !sr_q && !any_req && (sw_sr_req || quiet_ok);
    sr_exit_o  = sr_q && (any_req || (by_sw_q ? !sw_sr_req : !cpu_deep_sleep));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q      <= 1'b0;
      by_sw_q   <= 1'b0;
      quiet_cnt <= '0;
    end else begin
      if (sr_enter_o) begin
        sr_q    <= 1'b1;
        by_sw_q <= sw_sr_req;
      end else if (sr_exit_o) begin
        sr_q    <= 1'b0;
      end
      if (!cpu_deep_sleep || any_req || sr_exit_o)
        quiet_cnt <= '0;
      else if (quiet_cnt != '1)
        quiet_cnt <= quiet_cnt + 1'b1;
    end
  end

  assign sr_active_o = sr_q;

  AST_SR_ENTRY_QUIET: assert property (@(posedge clk) disable iff (rst)
    $rose(sr_q) |-> $past(!any_req)); // R5
  AST_SR_EXIT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(sr_q) |-> $past(any_req || !sw_sr_req || !cpu_deep_sleep)); // R6
endmodule

// File: rtl/pin_oe_ctrl.sv
module pin_oe_ctrl #(
  parameter int NUM_RANKS      = 4,
  parameter int RANKS_PER_SLOT = 2,
  localparam int NUM_SLOTS     = (NUM_RANKS + RANKS_PER_SLOT - 1) / RANKS_PER_SLOT
) (
  input  logic [NUM_RANKS-1:0] populated,
  input  logic [NUM_RANKS-1:0] rank_awake,
  input  logic [NUM_RANKS-1:0] cs_req,
  output logic                 addr_cmd_oe,
  output logic [NUM_RANKS-1:0] cs_oe,
  output logic [NUM_RANKS-1:0] cke_oe,
  output logic [NUM_SLOTS-1:0] clk_oe
);
  always_comb begin
    clk_oe = '0;
    for (int r = 0; r < NUM_RANKS; r++)
      clk_oe[r / RANKS_PER_SLOT] = clk_oe[r / RANKS_PER_SLOT] | populated[r];
  end

  assign cke_oe      = populated;
  assign cs_oe       = populated & rank_awake;
  assign addr_cmd_oe = (|(cs_req & populated)) && (|(populated & rank_awake));
endmodule

// File: rtl/dram_rank_pd_ctrl.sv
module dram_rank_pd_ctrl
  import rank_pd_pkg::*;
#(
  parameter int NUM_RANKS      = 4,
  parameter int RANKS_PER_SLOT = 2,
  parameter int IDLE_W         = 8,
  parameter int QUIET_W        = 8,
  parameter int PD_EXIT_CYC    = 4,
  parameter int SR_EXIT_CYC    = 32,
  localparam int NUM_SLOTS     = (NUM_RANKS + RANKS_PER_SLOT - 1) / RANKS_PER_SLOT
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_RANKS-1:0]   rank_populated,
  input  logic [NUM_RANKS-1:0]   bank_open,
  input  logic [NUM_RANKS-1:0]   req_pending,
  input  logic [NUM_RANKS-1:0]   cs_req,
  input  logic                   cpu_deep_sleep,
  input  logic                   sw_sr_req,
  input  logic [IDLE_W-1:0]      idle_limit,
  input  logic [QUIET_W-1:0]     quiet_limit,
  output logic [NUM_RANKS-1:0]   cke,
  output logic [2*NUM_RANKS-1:0] rank_state,
  output logic [NUM_RANKS-1:0]   rank_ready,
  output logic                   sr_active,
  output logic                   addr_cmd_oe,
  output logic [NUM_RANKS-1:0]   cs_oe,
  output logic [NUM_RANKS-1:0]   cke_oe,
  output logic [NUM_SLOTS-1:0]   clk_oe
);
  localparam int EXIT_MAX = (PD_EXIT_CYC > SR_EXIT_CYC) ? PD_EXIT_CYC : SR_EXIT_CYC;
  localparam int EXIT_W   = $clog2(EXIT_MAX + 1);

  logic [NUM_RANKS-1:0] req_live;
  logic [NUM_RANKS-1:0] awake;
  logic [NUM_RANKS-1:0] in_sr_or_empty;
  logic                 sr_enter, sr_exit;
  rank_pst_e            st_w [NUM_RANKS];

  assign req_live = req_pending & rank_populated;

  sr_ctrl #(.QUIET_W(QUIET_W)) u_sr (
    .clk, .rst,
    .any_req        (|req_live),
    .cpu_deep_sleep (cpu_deep_sleep),
    .sw_sr_req      (sw_sr_req),
    .quiet_limit    (quiet_limit),
    .sr_active_o    (sr_active),
    .sr_enter_o     (sr_enter),
    .sr_exit_o      (sr_exit)
  );

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    rank_pd_fsm #(
      .IDLE_W(IDLE_W), .EXIT_W(EXIT_W),
      .PD_EXIT_CYC(PD_EXIT_CYC), .SR_EXIT_CYC(SR_EXIT_CYC)
    ) u_fsm (
      .clk, .rst,
      .populated  (rank_populated[r]),
      .bank_open  (bank_open[r]),
      .req        (req_live[r]),
      .idle_limit (idle_limit),
      .sr_enter   (sr_enter),
      .sr_exit    (sr_exit),
      .state_o    (st_w[r]),
      .ready_o    (rank_ready[r])
    );
    assign awake[r]              = (st_w[r] == PST_ACT);
    assign cke[r]                = rank_populated[r] && awake[r];
    assign rank_state[2*r +: 2]  = st_w[r];
    assign in_sr_or_empty[r]     = (st_w[r] == PST_SR) || !rank_populated[r];
  end

  pin_oe_ctrl #(.NUM_RANKS(NUM_RANKS), .RANKS_PER_SLOT(RANKS_PER_SLOT)) u_pins (
    .populated   (rank_populated),
    .rank_awake  (awake),
    .cs_req      (cs_req),
    .addr_cmd_oe (addr_cmd_oe),
    .cs_oe       (cs_oe),
    .cke_oe      (cke_oe),
    .clk_oe      (clk_oe)
  );

  AST_SR_ALL_RANKS: assert property (@(posedge clk) disable iff (rst)
    sr_active |-> (&in_sr_or_empty)); // R4
  AST_ADDR_OE_NEEDS_CKE: assert property (@(posedge clk) disable iff (rst)
    addr_cmd_oe |-> (|cke)); // R7
  AST_EMPTY_RANK_QUIET: assert property (@(posedge clk) disable iff (rst)
    (~rank_populated & (cke | rank_ready | cs_oe)) == '0); // R9
endmodule

// File: tb/dram_rank_pd_ctrl_tb.sv
module dram_rank_pd_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NR  = 4;
  localparam int RPS = 2;
  localparam int NS  = (NR + RPS - 1) / RPS;
  localparam int IW  = 8;
  localparam int QW  = 8;
  localparam int PDX = 4;
  localparam int SRX = 32;

  logic clk = 1'b0;
  logic rst;
  logic [NR-1:0] pop, bopen, req, cs;
  logic deep, sw;
  logic [IW-1:0] idle_lim;
  logic [QW-1:0] quiet_lim;
  logic [NR-1:0] cke, ready, cs_oe, cke_oe;
  logic [2*NR-1:0] rstate;
  logic sr_act, addr_oe;
  logic [NS-1:0] clk_oe;

  int n_cmp = 0, n_fail = 0;
  bit done = 0;

  int m_st[NR], m_idle[NR], m_exit[NR];
  int m_sr, m_bysw, m_quiet;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_rank_pd_ctrl #(.NUM_RANKS(NR), .RANKS_PER_SLOT(RPS), .IDLE_W(IW), .QUIET_W(QW),
                      .PD_EXIT_CYC(PDX), .SR_EXIT_CYC(SRX)) dut_i (
    .clk(clk), .rst(rst), .rank_populated(pop), .bank_open(bopen), .req_pending(req),
    .cs_req(cs), .cpu_deep_sleep(deep), .sw_sr_req(sw), .idle_limit(idle_lim),
    .quiet_limit(quiet_lim), .cke(cke), .rank_state(rstate), .rank_ready(ready),
    .sr_active(sr_act), .addr_cmd_oe(addr_oe), .cs_oe(cs_oe), .cke_oe(cke_oe), .clk_oe(clk_oe));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int r = 0; r < NR; r++) begin m_st[r] = 0; m_idle[r] = 0; m_exit[r] = 0; end
    m_sr = 0; m_bysw = 0; m_quiet = 0;
  endtask

  task automatic model_update();
    bit anyreq, qok, enter, leave;
    int lim, qlim;
    if (rst) begin model_reset(); return; end
    anyreq = |(req & pop);
    lim  = (idle_lim == 0) ? 1 : idle_lim;
    qlim = (quiet_lim == 0) ? 1 : quiet_lim;
    qok   = deep && !anyreq && (m_quiet + 1 >= qlim);
    enter = !m_sr && !anyreq && (sw || qok);
    leave = m_sr && (anyreq || (m_bysw ? !sw : !deep));
    for (int r = 0; r < NR; r++) begin
      if (!pop[r]) begin m_st[r] = 0; m_idle[r] = 0; m_exit[r] = 0; end
      else if (enter) begin m_st[r] = 3; m_idle[r] = 0; m_exit[r] = 0; end
      else if (leave) begin m_st[r] = 0; m_idle[r] = 0; m_exit[r] = SRX; end
      else if (m_st[r] == 0) begin
        if (m_exit[r] > 0) begin m_exit[r]--; m_idle[r] = 0; end
        else if (req[r]) m_idle[r] = 0;
        else if (m_idle[r] + 1 >= lim) begin m_st[r] = bopen[r] ? 1 : 2; m_idle[r] = 0; end
        else m_idle[r]++;
      end else if (m_st[r] != 3 && req[r]) begin
        m_st[r] = 0; m_exit[r] = PDX;
      end
    end
    if (enter) begin m_sr = 1; m_bysw = sw; end
    else if (leave) m_sr = 0;
    if (!deep || anyreq || leave) m_quiet = 0;
    else if (m_quiet < (1 << QW) - 1) m_quiet++;
  endtask

  task automatic compare_all();
    logic [2*NR-1:0] e_st;
    logic [NR-1:0] e_cke, e_rdy;
    logic [NS-1:0] e_clk;
    logic any_awake;
    e_clk = '0; any_awake = 0;
    for (int r = 0; r < NR; r++) begin
      e_st[2*r +: 2] = 2'(m_st[r]);
      e_cke[r] = pop[r] && m_st[r] == 0;
      e_rdy[r] = e_cke[r] && m_exit[r] == 0;
      if (pop[r]) e_clk[r / RPS] = 1'b1;
      if (e_cke[r]) any_awake = 1;
    end
    chk("R2 state", 32'(rstate), 32'(e_st));
    chk("R1 cke", 32'(cke), 32'(e_cke));
    chk("R3 ready", 32'(ready), 32'(e_rdy));
    chk("R4 sr_active", 32'(sr_act), 32'(m_sr));
    chk("R7 addr_oe", 32'(addr_oe), 32'((|(cs & pop)) && any_awake));
    chk("R8 cs_oe", 32'(cs_oe), 32'(e_cke));
    chk("R9 cke_oe/clk_oe", 32'({clk_oe, cke_oe}), 32'({e_clk, pop}));
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      #(CLK_PERIOD/4);
      compare_all();
      @(posedge clk);
      model_update();
      @(negedge clk);
    end
  endtask

  task automatic do_reset(logic [NR-1:0] p);
    rst = 1'b1; pop = p; req = '0; cs = '0; deep = 0; sw = 0;
    repeat (3) @(posedge clk);
    model_reset();
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_cmp++; n_fail++;
      $display("FAIL R10 watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end

  initial begin
    bopen = 4'b0001; idle_lim = 16; quiet_lim = 8;
    do_reset(4'b0111);
    #1;
    chk("R10 state", 32'(rstate), 0);
    chk("R10 cke", 32'(cke), 32'h7);
    chk("R10 ready", 32'(ready), 32'h7);
    chk("R10 sr_active", 32'(sr_act), 0);
    // idle entry and power-down flavour
    step(15);
    chk("R1 still awake", 32'(rstate), 0);
    step(1);
    chk("R2 flavour", 32'(rstate), 32'h29);
    chk("R1 cke low", 32'(cke), 0);
    // wake rank 2
    req = 4'b0100; step(1); req = '0;
    chk("R3 woke", 32'(rstate), 32'h09);
    chk("R3 held", 32'(ready), 0);
    step(3);
    chk("R3 held", 32'(ready), 0);
    step(1);
    chk("R3 ready", 32'(ready), 32'h4);
    // pin enables
    cs = 4'b0100; #1;
    chk("R7 oe on", 32'(addr_oe), 1);
    chk("R8 cs_oe", 32'(cs_oe), 32'h4);
    step(1);
    cs = '0; #1;
    chk("R7 oe off", 32'(addr_oe), 0);
    step(1);
    // sleep self-refresh, request to an empty rank is ignored
    deep = 1; req = 4'b1000;
    step(7);
    chk("R4 not yet", 32'(sr_act), 0);
    step(1);
    chk("R4 entered", 32'(rstate), 32'h3F);
    chk("R9 empty req ignored", 32'(sr_act), 1);
    cs = 4'b0001; #1;
    chk("R7 all asleep", 32'(addr_oe), 0);
    cs = '0;
    // request exit
    req = 4'b0010; deep = 0; step(1); req = '0;
    chk("R6 req exit", 32'(rstate), 0);
    chk("R6 held", 32'(ready), 0);
    step(31);
    chk("R6 held", 32'(ready), 0);
    step(1);
    chk("R6 ready", 32'(ready), 32'h7);
    // software forcing
    sw = 1; step(1);
    chk("R5 forced", 32'(rstate), 32'h3F);
    step(3);
    sw = 0; step(1);
    chk("R6 sw clear", 32'(rstate), 0);
    step(32);
    deep = 1; step(8);
    chk("R4 sleep entry", 32'(rstate), 32'h3F);
    deep = 0; step(1);
    chk("R6 sleep release", 32'(rstate), 0);
    step(32);
    sw = 1; step(1);
    req = 4'b0001; step(1);
    chk("R6 req under sw", 32'(rstate), 0);
    req = '0; step(1);
    chk("R5 re-entry", 32'(rstate), 32'h3F);
    sw = 0; step(2);
    // unpopulated ranks and slot clocks
    bopen = '0; idle_lim = 4;
    do_reset(4'b0011);
    #1;
    chk("R9 clk_oe", 32'(clk_oe), 32'h1);
    chk("R9 cke_oe", 32'(cke_oe), 32'h3);
    req = 4'b1100; step(4);
    chk("R9 empty req ignored", 32'(rstate), 32'h0A);
    req = '0; idle_lim = 0; step(2);
    // random traffic
    do_reset(4'b1011);
    idle_lim = 3; quiet_lim = 5;
    for (int i = 0; i < 1500; i++) begin
      req   = 4'($urandom_range(0, 15) & $urandom_range(0, 15) & $urandom_range(0, 15));
      bopen = 4'($urandom_range(0, 15));
      cs    = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 19) == 0) deep = ~deep;
      if ($urandom_range(0, 39) == 0) sw = ~sw;
      if ($urandom_range(0, 99) == 0) idle_lim = 8'($urandom_range(0, 6));
      step(1);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end
endmodule